// File: doc/BRIEF.md
# I2C Target Address Responder

This block is the target side of a two-wire I2C bus. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and shifts in the address byte that follows each START. When the 7-bit address matches the programmed own address and the block is enabled, it pulls SDA low for the acknowledge clock. It then either collects bytes written by the controller into a receive holding register, or serialises bytes from a transmit holding register when the controller reads.

Software loads the own address before issuing the enable command. It keeps the transmit holding register filled during read transfers, and it reads received bytes out of the receive holding register. Two status outputs follow the traffic. `txn_done` tracks bus framing. `rx_ready` tracks whether the receive holding register has unread content. A disable command does not cut a transfer off mid-byte: the block finishes the byte it is on, and in reads it also sends any byte still waiting in the holding register, before it goes quiet.

Top module: `i2c_target_responder`

## Requirements
- R1: After synchronous reset, `sda_oe`=0, `rx_ready`=0, `slave_on`=0 and `txn_done`=1.
- R2: A START (SDA falls while SCL is high) clears `txn_done`. A STOP (SDA rises while SCL is high) sets it.
- R3: The address byte is 7 address bits sent MSB first, then a direction bit (1 = controller reads). The block drives `sda_oe`=1 (SDA low) in the ninth clock only when those 7 bits equal `own_addr` and the block is enabled. When they differ, SDA stays released for the rest of that frame: no data byte is acknowledged and `rx_ready` is untouched.
- R4: An address byte that does not match sets `txn_done` at the end of its eighth bit, before any STOP. This covers a repeated START that carries another target's address.
- R5: In a write transfer, each complete byte is copied into `rx_data`, sets `rx_ready`, and is acknowledged in the ninth clock.
- R6: A one-cycle `rx_rd` pulse clears `rx_ready`, unless a new byte lands in the same cycle.
- R7: In a read transfer, the transmit holding register is moved into the shifter on the falling SCL edge that ends the address acknowledge, and again at the end of each acknowledge clock in which the controller acknowledges. Bits go out MSB first. An empty holding register yields 0xFF. A not-acknowledge from the controller ends the response until the next START.
- R8: `en_cmd` sets `slave_on`. A disabled block acknowledges no address. `dis_cmd` issued while no transfer is in progress clears `slave_on` within two cycles. While `slave_on` is 0, `sda_oe` is 0.
- R9: `dis_cmd` during a controller write lets the byte in progress complete and be acknowledged. After that the block releases SDA, clears `slave_on`, and acknowledges no further byte.
- R10: `dis_cmd` during a controller read lets the byte in the shifter and any byte in the holding register both be sent. After that the block releases SDA and clears `slave_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr | input | 7 | Programmed target address |
| en_cmd | input | 1 | One-cycle enable command |
| dis_cmd | input | 1 | One-cycle disable command |
| tx_data | input | 8 | Byte for the transmit holding register |
| tx_wr | input | 1 | Loads `tx_data` into the transmit holding register |
| rx_data | output | 8 | Receive holding register |
| rx_rd | input | 1 | Software read strobe of `rx_data` |
| rx_ready | output | 1 | Unread byte present in `rx_data` |
| txn_done | output | 1 | Transfer-complete flag following bus framing |
| slave_on | output | 1 | Block currently responds to its address |

## Verification
The assertions assume that the controller moves SDA only while SCL is low, except when it creates START and STOP. They also assume that every SCL high and low phase lasts longer than the synchronizer delay, so each edge is seen as exactly one event. Under those assumptions, the acknowledge drive changes only one cycle after a detected SCL fall or a framing event. The bench bit-bangs the bus with ten-cycle phases, changes SDA only in the low phase of SCL, and ends every read with a not-acknowledge so that the target has released SDA before STOP.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

    localparam int ADDR_BITS = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [ADDR_BITS:0] frame,
                                      input logic [ADDR_BITS-1:0] own);
        return frame[ADDR_BITS:1] == own;
    endfunction

endpackage

// File: rtl/i2ct_linemon.sv
`timescale 1ns/1ps
module i2ct_linemon
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_q, sda_q;
    logic scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_n;
            sda_q    <= sda_n;
        end
    end

    assign scl_n = scl_sync[SYNC_STAGES-1];
    assign sda_n = sda_sync[SYNC_STAGES-1];

    always_comb begin
        evt.start = scl_n & scl_q & sda_q & ~sda_n;
        evt.stop  = scl_n & scl_q & ~sda_q & sda_n;
        evt.rise  = scl_n & ~scl_q;
        evt.fall  = ~scl_n & scl_q;
        evt.sda   = sda_n;
    end
endmodule

// File: rtl/i2ct_mode.sv
`timescale 1ns/1ps
module i2ct_mode (
    input  logic clk,
    input  logic rst,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic eng_idle,
    output logic active,
    output logic leaving
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            leaving <= 1'b0;
        end else if (en_cmd) begin
            active  <= 1'b1;
            leaving <= 1'b0;
        end else if (active && (leaving || dis_cmd) && eng_idle) begin
            active  <= 1'b0;
            leaving <= 1'b0;
        end else if (active && dis_cmd) begin
            leaving <= 1'b1;
        end
    end
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 active,
    input  logic                 leaving,
    input  logic [DATA_W-1:0]    tx_data,
    input  logic                 tx_wr,
    input  logic                 rx_rd,
    output logic                 sda_oe,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 rx_ready,
    output logic                 txn_done,
    output logic                 rx_store,
    output logic                 eng_idle
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ABYTE = CNT_W'(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] DBYTE = CNT_W'(DATA_W);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh_in, sh_out, hold;
    logic              hold_full, rw, nack;
    logic [DATA_W-1:0] next_byte;
    logic              addr_ok;

    assign next_byte = hold_full ? hold : '1;
    assign addr_ok   = active && !leaving && addr_hit(sh_in[ADDR_BITS:0], own_addr);
    assign rx_store  = (state == ST_WR) && evt.fall && (cnt == DBYTE)
                       && !evt.start && !evt.stop;
    assign eng_idle  = (state == ST_IDLE) || (state == ST_SKIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sh_in     <= '0;
            sh_out    <= '1;
            hold      <= '0;
            hold_full <= 1'b0;
            rw        <= 1'b0;
            nack      <= 1'b0;
            sda_oe    <= 1'b0;
            rx_data   <= '0;
            rx_ready  <= 1'b0;
            txn_done  <= 1'b1;
        end else begin
            if (rx_rd) rx_ready <= 1'b0;

            if (evt.start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                txn_done <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                txn_done <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.rise && cnt < ABYTE) begin
                            sh_in <= {sh_in[DATA_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.fall && cnt == ABYTE) begin
                            if (addr_ok) begin
                                sda_oe <= 1'b1;
                                rw     <= sh_in[0];
                                state  <= ST_AACK;
                            end else begin
                                state    <= ST_SKIP;
                                txn_done <= 1'b1;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) begin
                            cnt <= '0;
                            if (rw) begin
                                sh_out    <= next_byte;
                                hold_full <= 1'b0;
                                sda_oe    <= ~next_byte[DATA_W-1];
                                state     <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (evt.rise && cnt < DBYTE) begin
                            sh_in <= {sh_in[DATA_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.fall && cnt == DBYTE) begin
                            rx_data  <= sh_in;
                            rx_ready <= 1'b1;
                            sda_oe   <= 1'b1;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= leaving ? ST_SKIP : ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (evt.rise && cnt < DBYTE) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall && cnt == DBYTE) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else if (evt.fall && cnt != '0) begin
                            sda_oe <= ~sh_out[DATA_W-2];
                            sh_out <= {sh_out[DATA_W-2:0], 1'b1};
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            nack <= evt.sda;
                        end else if (evt.fall) begin
                            if (nack || (leaving && !hold_full)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_SKIP;
                            end else begin
                                cnt       <= '0;
                                sh_out    <= next_byte;
                                hold_full <= 1'b0;
                                sda_oe    <= ~next_byte[DATA_W-1];
                                state     <= ST_RD;
                            end
                        end
                    end
                    default: ;
                endcase
            end

            if (tx_wr) begin
                hold      <= tx_data;
                hold_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_target_responder.sv
`timescale 1ns/1ps
module i2c_target_responder
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 en_cmd,
    input  logic                 dis_cmd,
    input  logic [DATA_W-1:0]    tx_data,
    input  logic                 tx_wr,
    output logic [DATA_W-1:0]    rx_data,
    input  logic                 rx_rd,
    output logic                 rx_ready,
    output logic                 txn_done,
    output logic                 slave_on
);
    bus_evt_t evt;
    logic     active, leaving, eng_idle, rx_store;
    logic     ev_start, ev_stop, ev_fall;

    assign ev_start = evt.start;
    assign ev_stop  = evt.stop;
    assign ev_fall  = evt.fall;
    assign slave_on = active;

    i2ct_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2ct_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .en_cmd   (en_cmd),
        .dis_cmd  (dis_cmd),
        .eng_idle (eng_idle),
        .active   (active),
        .leaving  (leaving)
    );

    i2ct_engine #(.DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr (own_addr),
        .active   (active),
        .leaving  (leaving),
        .tx_data  (tx_data),
        .tx_wr    (tx_wr),
        .rx_rd    (rx_rd),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .txn_done (txn_done),
        .rx_store (rx_store),
        .eng_idle (eng_idle)
    );
endmodule

// File: rtl/i2ct_checker.sv
`timescale 1ns/1ps
module i2ct_checker (
    input logic clk,
    input logic rst,
    input logic ev_start,
    input logic ev_stop,
    input logic ev_fall,
    input logic sda_oe,
    input logic slave_on,
    input logic rx_rd,
    input logic rx_store,
    input logic rx_ready,
    input logic txn_done
);
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !txn_done);

    a_r2_stop_sets_done: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> txn_done);

    a_r5_store_flags_ready: assert property (@(posedge clk) disable iff (rst)
        rx_store |=> rx_ready);

    a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !rx_store) |=> !rx_ready);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !slave_on |-> !sda_oe);

    a_r7_drive_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop));
endmodule

bind i2c_target_responder i2ct_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_fall  (ev_fall),
    .sda_oe   (sda_oe),
    .slave_on (slave_on),
    .rx_rd    (rx_rd),
    .rx_store (rx_store),
    .rx_ready (rx_ready),
    .txn_done (txn_done)
);

// File: tb/i2c_target_responder_test.sv
`timescale 1ns/1ps
module i2c_target_responder_test;
    localparam int Q = 10;
    localparam logic [6:0] OWN = 7'h2B;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, sda_bus;
    logic [6:0] own_addr = OWN;
    logic       en_cmd = 1'b0, dis_cmd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, txn_done, slave_on;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_target_responder uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(own_addr), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .tx_data(tx_data), .tx_wr(tx_wr), .rx_data(rx_data), .rx_rd(rx_rd),
        .rx_ready(rx_ready), .txn_done(txn_done), .slave_on(slave_on)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        acked = (sda_bus == 1'b0);
        tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q/2);
            v[i] = sda_bus;
            tick(Q/2);
            scl_m = 1'b0;
        end
        sda_m = ~ack; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; sda_m = 1'b1; tick(Q);
    endtask

    task automatic pulse_en();  en_cmd = 1'b1;  tick(1); en_cmd = 1'b0;  tick(2); endtask
    task automatic pulse_dis(); dis_cmd = 1'b1; tick(1); dis_cmd = 1'b0; endtask
    task automatic load_tx(input logic [7:0] b); tx_data = b; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; endtask
    task automatic read_rx(); rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1); endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 slave_on", slave_on, 0);
        chk("R1 txn_done", txn_done, 1);

        // R8 disabled block does not answer its own address
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R8 no ack while disabled", ack, 0);
        bus_stop();

        pulse_en();
        chk("R8 slave_on after enable", slave_on, 1);

        // R3/R4/R2 sweep of every address, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            chk("R2 start clears done", txn_done, 0);
            send_byte({a[6:0], 1'b0}, ack);
            chk("R3 ack only on match", ack, (a == OWN) ? 1 : 0);
            if (a != OWN) chk("R4 mismatch sets done", txn_done, 1);
            if (a == 7'h2A) begin
                send_byte(8'h00, ack);
                chk("R3 ignored frame data not acked", ack, 0);
                chk("R3 ignored frame rx_ready", rx_ready, 0);
            end
            bus_stop();
            chk("R2 stop sets done", txn_done, 1);
        end

        // R5/R6 write transfer
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R5 address ack", ack, 1);
        begin
            logic [7:0] pat [4] = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
            for (int k = 0; k < 4; k++) begin
                send_byte(pat[k], ack);
                chk("R5 data ack", ack, 1);
                chk("R5 rx_ready set", rx_ready, 1);
                chk("R5 rx_data", rx_data, pat[k]);
                read_rx();
                chk("R6 rx_ready cleared", rx_ready, 0);
            end
        end
        bus_stop();

        // R7 read transfer, two bytes, MSB first
        load_tx(8'hC3);
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk("R7 read address ack", ack, 1);
        load_tx(8'h81);
        get_byte(1'b1, v);
        chk("R7 first byte", v, 8'hC3);
        get_byte(1'b0, v);
        chk("R7 second byte", v, 8'h81);
        bus_stop();

        // R7 empty holding register gives all ones
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        get_byte(1'b0, v);
        chk("R7 empty hold yields FF", v, 8'hFF);
        bus_stop();

        // R4 repeated START: matching keeps done low, other target sets it
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h11, ack);
        read_rx();
        bus_start();
        chk("R2 repeated start done", txn_done, 0);
        send_byte({OWN, 1'b0}, ack);
        chk("R4 repeated match ack", ack, 1);
        chk("R4 repeated match done low", txn_done, 0);
        bus_start();
        send_byte({7'h10, 1'b0}, ack);
        chk("R4 repeated other no ack", ack, 0);
        chk("R4 repeated other done", txn_done, 1);
        bus_stop();

        // R9 disable during write
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        pulse_dis();
        send_byte(8'h5A, ack);
        chk("R9 byte in progress acked", ack, 1);
        chk("R9 byte stored", rx_data, 8'h5A);
        chk("R9 slave_on cleared", slave_on, 0);
        read_rx();
        send_byte(8'h77, ack);
        chk("R9 next byte not acked", ack, 0);
        chk("R9 next byte not stored", rx_ready, 0);
        bus_stop();

        // R10 disable during read
        pulse_en();
        load_tx(8'h96);
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        load_tx(8'h69);
        pulse_dis();
        get_byte(1'b1, v);
        chk("R10 shifter byte sent", v, 8'h96);
        chk("R10 still on with held byte", slave_on, 1);
        get_byte(1'b1, v);
        chk("R10 held byte sent", v, 8'h69);
        chk("R10 slave_on cleared", slave_on, 0);
        get_byte(1'b0, v);
        chk("R10 released after drain", v, 8'hFF);
        bus_stop();

        // R8 disable while idle
        pulse_en();
        pulse_dis();
        tick(2);
        chk("R8 idle disable", slave_on, 0);

        summary();
        $finish;
    end
endmodule